// File: doc/BRIEF.md
# Four-Channel Double-Buffered PWM Controller

The block generates four independent pulse-width-modulated outputs under control of a simple word-addressed register bus (address, write data, write strobe, read strobe, registered read data). Each channel owns a power-of-two clock prescaler, a 16-bit counter that runs from zero to the period minus one, a duty comparator and a polarity select. New duty and period values are written to update registers and are copied into the active registers only when the channel reaches the end of a period. This keeps every output period whole, with no glitch.

A shared set of control registers starts channels, asks channels to stop, reports which channels are running and records period-end events. A stop request is deferred: the channel finishes the period it is in before it drops its running flag. Software can therefore stop a channel without cutting a pulse short. The event register is cleared by reading it, so software can poll it to find out when a requested update has taken effect.

Top module: `pwm_quad_ctrl`

## Requirements
- R1: After a synchronous reset every register reads zero, every channel is stopped (`run_o` = 0), `rdata_o` is 0 and every `pwm_o` pin is low.
- R2: Writing the start register (offset 0x004) with bit n set starts channel n, or restarts it if it is already running, with its counter and prescaler at zero, and cancels any pending stop. Bits written as 0 have no effect. Bit n of the status register (offset 0x00C, read-only) and of `run_o` is 1 while channel n runs.
- R3: Writing the stop register (offset 0x008) with bit n set on a running channel stops it at the end of its current period. The running flag clears at the clock edge where that period ends. A stop request on a stopped channel is ignored. A request that arrives in the cycle a period ends takes effect at the end of the next period.
- R4: Bits [3:0] of a channel's mode register (offset +0x00) hold an exponent p. While the channel runs, its counter advances once every 2^p clocks. Values above 10 act as 10.
- R5: The counter counts 0 to period−1 and then wraps. A period end is the advancing step taken from count period−1, or every advancing step when the period is 0. The uninverted waveform is high while duty ≤ count < period and low otherwise. A duty at or above the period gives no high time, and a period of 0 keeps the waveform low. `pwm_o` shows the waveform one clock after the state that produces it.
- R6: Bit 9 of the mode register inverts the pin. A stopped channel drives its pin to the value of bit 9. Mode writes take effect at once.
- R7: A write to the duty-update register (+0x08) or the period-update register (+0x10) is copied into the active duty (+0x04) or active period (+0x0C) at the next period end. If no such write has occurred since the last copy, nothing is copied at a period end. Writes to the active registers change them directly while the channel is stopped and are ignored while it runs.
- R8: Bit n of the event register (offset 0x01C) is set one clock after a period end of channel n. A read of this register returns its value and clears all bits, except that an event arriving in the same cycle as the read is kept.
- R9: Channel n's registers start at 0x200 + n·0x20. Duty and period fields are 16 bits wide: the upper write bits are dropped and the upper read bits are 0. `rdata_o` carries the addressed value in the clock after `re_i`. It is 0 in every other cycle and 0 for any unmapped address, including the start and stop registers.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr_i | input | 12 | Byte address of the register access |
| wdata_i | input | 32 | Write data |
| we_i | input | 1 | Write strobe, one access per cycle |
| re_i | input | 1 | Read strobe |
| rdata_o | output | 32 | Registered read data |
| pwm_o | output | 4 | PWM pins, one per channel |
| run_o | output | 4 | Per-channel running flags |

## Verification
The assertions check the following on every cycle: a running flag only falls right after a period end of that channel, each period end shows up in the event register, a read of the event register with no new event leaves it empty, a stopped channel drives its polarity level, a running counter stays below its period, and read data is zero without a read strobe. Only the bench's scenarios can show the exact waveform timing for a given duty and period, the prescaler rate (including the clamp above 10), the moment a shadowed value is copied, restart on a repeated start, and the readback of each register. The bench shows these by comparing against a behavioural model on every clock.

// File: rtl/pwmc_pkg.sv
package pwmc_pkg;
  localparam int MODE_EXP_W   = 4;
  localparam int MODE_POL_BIT = 9;
  localparam int CH_LG        = 5;
  localparam int CH_STRIDE    = 1 << CH_LG;
  localparam int CH_BASE_ADDR = 'h200;
  localparam int OFF_START    = 'h004;
  localparam int OFF_STOP     = 'h008;
  localparam int OFF_STAT     = 'h00C;
  localparam int OFF_EVT      = 'h01C;

  typedef enum logic [CH_LG-1:0] {
    RG_MODE     = 5'h00,
    RG_DUTY     = 5'h04,
    RG_DUTY_UPD = 5'h08,
    RG_PRD      = 5'h0C,
    RG_PRD_UPD  = 5'h10
  } creg_e;

  typedef struct packed {
    logic                  pol;
    logic [MODE_EXP_W-1:0] pexp;
  } mode_t;
endpackage

// File: rtl/pwmc_prescaler.sv
module pwmc_prescaler
  import pwmc_pkg::*;
#(
  parameter int EXP_MAX = 10
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  restart,
  input  logic [MODE_EXP_W-1:0] exp_i,
  output logic                  tick_o
);
  localparam int ACC_W = (EXP_MAX < 1) ? 1 : EXP_MAX;

  logic [ACC_W-1:0] acc;
  logic [ACC_W-1:0] mask;
  int               e_lim;

  // Mask of the low bits that must be all ones for a tick; exponent clamped.
  always_comb begin
    e_lim  = (int'(exp_i) > EXP_MAX) ? EXP_MAX : int'(exp_i);
    mask   = ACC_W'((1 << e_lim) - 1);
    tick_o = ((acc & mask) == mask);
  end

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      acc <= '0;
    end else if (tick_o) begin
      acc <= '0;
    end else begin
      acc <= acc + ACC_W'(1);
    end
  end
endmodule

// File: rtl/pwmc_chan.sv
module pwmc_chan
  import pwmc_pkg::*;
#(
  parameter int VW      = 16,
  parameter int EXP_MAX = 10
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en_req,
  input  logic          dis_req,
  input  logic          wr_mode,
  input  logic          wr_duty,
  input  logic          wr_duty_upd,
  input  logic          wr_prd,
  input  logic          wr_prd_upd,
  input  logic [VW-1:0] val_i,
  input  mode_t         mode_i,
  output mode_t         mode_o,
  output logic [VW-1:0] duty_o,
  output logic [VW-1:0] duty_upd_o,
  output logic [VW-1:0] prd_o,
  output logic [VW-1:0] prd_upd_o,
  output logic [VW-1:0] cnt_o,
  output logic          running_o,
  output logic          end_o,
  output logic          pin_o
);
  mode_t         mode_q;
  logic [VW-1:0] duty_q, duty_sh, prd_q, prd_sh, cnt_q;
  logic          duty_pend, prd_pend;
  logic          run_q, stop_pend, pin_q;
  logic          tick;
  logic [VW:0]   cnt_inc;
  logic          wave;

  pwmc_prescaler #(.EXP_MAX(EXP_MAX)) u_pre (
    .clk     (clk),
    .rst     (rst),
    .restart (en_req),
    .exp_i   (mode_q.pexp),
    .tick_o  (tick)
  );

  assign cnt_inc = {1'b0, cnt_q} + (VW+1)'(1);
  assign end_o   = run_q & tick & (cnt_inc >= {1'b0, prd_q});
  assign wave    = run_q && (cnt_q >= duty_q) && (cnt_q < prd_q);

  // Mode register: immediate effect.
  always_ff @(posedge clk) begin
    if (rst)          mode_q <= '0;
    else if (wr_mode) mode_q <= mode_i;
  end

  // Duty: shadow with pending flag, active loaded at period end or direct when stopped.
  always_ff @(posedge clk) begin
    if (rst) begin
      duty_q    <= '0;
      duty_sh   <= '0;
      duty_pend <= 1'b0;
    end else begin
      if (end_o && duty_pend)    duty_q <= duty_sh;
      else if (wr_duty && !run_q) duty_q <= val_i;
      if (wr_duty_upd) begin
        duty_sh   <= val_i;
        duty_pend <= 1'b1;
      end else if (end_o) begin
        duty_pend <= 1'b0;
      end
    end
  end

  // Period: same double-buffer scheme.
  always_ff @(posedge clk) begin
    if (rst) begin
      prd_q    <= '0;
      prd_sh   <= '0;
      prd_pend <= 1'b0;
    end else begin
      if (end_o && prd_pend)    prd_q <= prd_sh;
      else if (wr_prd && !run_q) prd_q <= val_i;
      if (wr_prd_upd) begin
        prd_sh   <= val_i;
        prd_pend <= 1'b1;
      end else if (end_o) begin
        prd_pend <= 1'b0;
      end
    end
  end

  // Run control with deferred stop.
  always_ff @(posedge clk) begin
    if (rst) begin
      run_q     <= 1'b0;
      stop_pend <= 1'b0;
    end else if (en_req) begin
      run_q     <= 1'b1;
      stop_pend <= 1'b0;
    end else if (end_o && stop_pend) begin
      run_q     <= 1'b0;
      stop_pend <= 1'b0;
    end else if (dis_req && run_q) begin
      stop_pend <= 1'b1;
    end
  end

  // Period counter.
  always_ff @(posedge clk) begin
    if (rst || en_req) begin
      cnt_q <= '0;
    end else if (run_q && tick) begin
      cnt_q <= end_o ? '0 : cnt_inc[VW-1:0];
    end
  end

  // Registered pin with polarity.
  always_ff @(posedge clk) begin
    if (rst) pin_q <= 1'b0;
    else     pin_q <= wave ^ mode_q.pol;
  end

  assign mode_o     = mode_q;
  assign duty_o     = duty_q;
  assign duty_upd_o = duty_sh;
  assign prd_o      = prd_q;
  assign prd_upd_o  = prd_sh;
  assign cnt_o      = cnt_q;
  assign running_o  = run_q;
  assign pin_o      = pin_q;
endmodule

// File: rtl/pwmc_evtreg.sv
module pwmc_evtreg #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] set_i,
  input  logic         rd_clr_i,
  output logic [N-1:0] evt_o
);
  always_ff @(posedge clk) begin
    if (rst) evt_o <= '0;
    else     evt_o <= (rd_clr_i ? '0 : evt_o) | set_i;
  end
endmodule

// File: rtl/pwm_quad_ctrl.sv
module pwm_quad_ctrl
  import pwmc_pkg::*;
#(
  parameter int NCH     = 4,
  parameter int VW      = 16,
  parameter int AW      = 12,
  parameter int DW      = 32,
  parameter int EXP_MAX = 10
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [AW-1:0]  addr_i,
  input  logic [DW-1:0]  wdata_i,
  input  logic           we_i,
  input  logic           re_i,
  output logic [DW-1:0]  rdata_o,
  output logic [NCH-1:0] pwm_o,
  output logic [NCH-1:0] run_o
);
  localparam logic [AW-1:0] CH_BASE = AW'(CH_BASE_ADDR);
  localparam logic [AW-1:0] CH_SPAN = AW'(NCH * CH_STRIDE);

  logic [AW-1:0]        ch_rel;
  logic [AW-1:0]        ch_sel;
  logic [CH_LG-1:0]     roff;
  logic                 in_ch;
  logic                 wr_start, wr_stop, rd_evt;
  logic [NCH-1:0]       end_vec;
  logic [NCH-1:0]       evt_q;
  logic [NCH-1:0]       ch_pol;
  logic [NCH-1:0][VW-1:0] ch_cnt;
  logic [NCH-1:0][VW-1:0] ch_prd;
  mode_t                ch_mode    [NCH];
  logic [VW-1:0]        ch_duty    [NCH];
  logic [VW-1:0]        ch_duty_sh [NCH];
  logic [VW-1:0]        ch_prd_sh  [NCH];
  logic [DW-1:0]        rd_val;
  mode_t                mode_wr;
  logic                 unused_wbits;

  assign ch_rel   = addr_i - CH_BASE;
  assign in_ch    = (addr_i >= CH_BASE) && (ch_rel < CH_SPAN);
  assign ch_sel   = ch_rel >> CH_LG;
  assign roff     = ch_rel[CH_LG-1:0];
  assign wr_start = we_i && (addr_i == AW'(OFF_START));
  assign wr_stop  = we_i && (addr_i == AW'(OFF_STOP));
  assign rd_evt   = re_i && (addr_i == AW'(OFF_EVT));
  assign mode_wr  = '{pol: wdata_i[MODE_POL_BIT], pexp: wdata_i[MODE_EXP_W-1:0]};
  assign unused_wbits = ^wdata_i[DW-1:VW];

  for (genvar n = 0; n < NCH; n++) begin : g_ch
    logic hit;
    assign hit = we_i && in_ch && (ch_sel == AW'(n));

    pwmc_chan #(.VW(VW), .EXP_MAX(EXP_MAX)) u_chan (
      .clk         (clk),
      .rst         (rst),
      .en_req      (wr_start && wdata_i[n]),
      .dis_req     (wr_stop && wdata_i[n]),
      .wr_mode     (hit && (roff == RG_MODE)),
      .wr_duty     (hit && (roff == RG_DUTY)),
      .wr_duty_upd (hit && (roff == RG_DUTY_UPD)),
      .wr_prd      (hit && (roff == RG_PRD)),
      .wr_prd_upd  (hit && (roff == RG_PRD_UPD)),
      .val_i       (wdata_i[VW-1:0]),
      .mode_i      (mode_wr),
      .mode_o      (ch_mode[n]),
      .duty_o      (ch_duty[n]),
      .duty_upd_o  (ch_duty_sh[n]),
      .prd_o       (ch_prd[n]),
      .prd_upd_o   (ch_prd_sh[n]),
      .cnt_o       (ch_cnt[n]),
      .running_o   (run_o[n]),
      .end_o       (end_vec[n]),
      .pin_o       (pwm_o[n])
    );
    assign ch_pol[n] = ch_mode[n].pol;
  end

  pwmc_evtreg #(.N(NCH)) u_evt (
    .clk      (clk),
    .rst      (rst),
    .set_i    (end_vec),
    .rd_clr_i (rd_evt),
    .evt_o    (evt_q)
  );

  always_comb begin
    rd_val = '0;
    if (addr_i == AW'(OFF_STAT)) begin
      rd_val[NCH-1:0] = run_o;
    end else if (addr_i == AW'(OFF_EVT)) begin
      rd_val[NCH-1:0] = evt_q;
    end else if (in_ch) begin
      for (int k = 0; k < NCH; k++) begin
        if (ch_sel == AW'(k)) begin
          case (roff)
            RG_MODE: begin
              rd_val[MODE_EXP_W-1:0] = ch_mode[k].pexp;
              rd_val[MODE_POL_BIT]   = ch_mode[k].pol;
            end
            RG_DUTY:     rd_val[VW-1:0] = ch_duty[k];
            RG_DUTY_UPD: rd_val[VW-1:0] = ch_duty_sh[k];
            RG_PRD:      rd_val[VW-1:0] = ch_prd[k];
            RG_PRD_UPD:  rd_val[VW-1:0] = ch_prd_sh[k];
            default:     rd_val = '0;
          endcase
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rdata_o <= '0;
    else     rdata_o <= re_i ? rd_val : '0;
  end
endmodule

// File: rtl/pwm_quad_chk.sv
module pwm_quad_chk #(
  parameter int NCH = 4,
  parameter int VW  = 16,
  parameter int DW  = 32
) (
  input logic                   clk,
  input logic                   rst,
  input logic                   re_i,
  input logic                   rd_evt,
  input logic [NCH-1:0]         end_vec,
  input logic [NCH-1:0]         evt_q,
  input logic [NCH-1:0]         run_o,
  input logic [NCH-1:0]         pwm_o,
  input logic [DW-1:0]          rdata_o,
  input logic [NCH-1:0]         ch_pol,
  input logic [NCH-1:0][VW-1:0] ch_cnt,
  input logic [NCH-1:0][VW-1:0] ch_prd
);
  for (genvar i = 0; i < NCH; i++) begin : g_a
    assert_stop_at_end_R3: assert property (@(posedge clk) disable iff (rst)
      $fell(run_o[i]) |-> $past(end_vec[i]));

    assert_evt_set_R8: assert property (@(posedge clk) disable iff (rst)
      end_vec[i] |=> evt_q[i]);

    assert_idle_level_R6: assert property (@(posedge clk) disable iff (rst)
      !run_o[i] |=> (pwm_o[i] == $past(ch_pol[i])));

    assert_cnt_range_R5: assert property (@(posedge clk) disable iff (rst)
      (run_o[i] && (ch_cnt[i] != '0)) |-> (ch_cnt[i] < ch_prd[i]));
  end

  assert_evt_clear_R8: assert property (@(posedge clk) disable iff (rst)
    (rd_evt && (end_vec == '0)) |=> (evt_q == '0));

  assert_rdata_idle_R9: assert property (@(posedge clk) disable iff (rst)
    !re_i |=> (rdata_o == '0));
endmodule

bind pwm_quad_ctrl pwm_quad_chk #(.NCH(NCH), .VW(VW), .DW(DW)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .re_i    (re_i),
  .rd_evt  (rd_evt),
  .end_vec (end_vec),
  .evt_q   (evt_q),
  .run_o   (run_o),
  .pwm_o   (pwm_o),
  .rdata_o (rdata_o),
  .ch_pol  (ch_pol),
  .ch_cnt  (ch_cnt),
  .ch_prd  (ch_prd)
);

// File: tb/pwm_quad_ctrl_tb.sv
module pwm_quad_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0;
  logic        we = 1'b0;
  logic        re = 1'b0;
  logic [31:0] rdata;
  logic [3:0]  pwm, run;

  always #10 clk = ~clk;

  pwm_quad_ctrl u_dut (
    .clk(clk), .rst(rst), .addr_i(addr), .wdata_i(wdata), .we_i(we), .re_i(re),
    .rdata_o(rdata), .pwm_o(pwm), .run_o(run)
  );

  // Behavioural reference state
  int m_pe[4], m_pol[4], m_duty[4], m_dsh[4], m_dp[4], m_prd[4], m_psh[4], m_pp[4];
  int m_cnt[4], m_pre[4], m_run[4], m_sp[4], m_pin[4];
  int m_evt;
  int m_rd;

  int    n_cmp = 0;
  int    n_bad = 0;
  int    cyc   = 0;
  string tag   = "R1";
  bit    armed = 0;
  bit    done  = 0;

  always @(posedge clk) begin
    int  e, mask, rdv, ch, off, ev, nd, np, nrun, nsp, ncnt, npre;
    int  tk[4], ep[4], pn[4];
    bit  chv, wch, st;
    armed = 1;
    if (rst) begin
      for (int n = 0; n < 4; n++) begin
        m_pe[n]=0; m_pol[n]=0; m_duty[n]=0; m_dsh[n]=0; m_dp[n]=0; m_prd[n]=0;
        m_psh[n]=0; m_pp[n]=0; m_cnt[n]=0; m_pre[n]=0; m_run[n]=0; m_sp[n]=0; m_pin[n]=0;
      end
      m_evt = 0;
      m_rd  = 0;
    end else begin
      for (int n = 0; n < 4; n++) begin
        e     = (m_pe[n] > 10) ? 10 : m_pe[n];
        mask  = (1 << e) - 1;
        tk[n] = ((m_pre[n] & mask) == mask) ? 1 : 0;
        ep[n] = (m_run[n] != 0 && tk[n] != 0 && (m_cnt[n] + 1 >= m_prd[n])) ? 1 : 0;
        pn[n] = ((m_run[n] != 0 && m_cnt[n] >= m_duty[n] && m_cnt[n] < m_prd[n]) ? 1 : 0) ^ m_pol[n];
      end
      chv = (addr >= 12'h200) && (addr < 12'h280);
      ch  = (int'(addr) - 'h200) / 32;
      off = (int'(addr) - 'h200) % 32;
      rdv = 0;
      if (re) begin
        if (addr == 12'h00C) begin
          for (int n = 0; n < 4; n++) rdv |= m_run[n] << n;
        end else if (addr == 12'h01C) begin
          rdv = m_evt;
        end else if (chv) begin
          case (off)
            0:  rdv = m_pe[ch] | (m_pol[ch] << 9);
            4:  rdv = m_duty[ch];
            8:  rdv = m_dsh[ch];
            12: rdv = m_prd[ch];
            16: rdv = m_psh[ch];
            default: rdv = 0;
          endcase
        end
      end
      m_rd = rdv;
      ev = 0;
      for (int n = 0; n < 4; n++) ev |= ep[n] << n;
      m_evt = ((re && addr == 12'h01C) ? 0 : m_evt) | ev;
      for (int n = 0; n < 4; n++) begin
        wch = we && chv && (ch == n);
        m_pin[n] = pn[n];
        nd = m_duty[n];
        if (ep[n] != 0 && m_dp[n] != 0) nd = m_dsh[n];
        else if (wch && off == 4 && m_run[n] == 0) nd = int'(wdata[15:0]);
        np = m_prd[n];
        if (ep[n] != 0 && m_pp[n] != 0) np = m_psh[n];
        else if (wch && off == 12 && m_run[n] == 0) np = int'(wdata[15:0]);
        if (wch && off == 8) begin m_dsh[n] = int'(wdata[15:0]); m_dp[n] = 1; end
        else if (ep[n] != 0) m_dp[n] = 0;
        if (wch && off == 16) begin m_psh[n] = int'(wdata[15:0]); m_pp[n] = 1; end
        else if (ep[n] != 0) m_pp[n] = 0;
        if (wch && off == 0) begin m_pe[n] = int'(wdata[3:0]); m_pol[n] = int'(wdata[9]); end
        st   = we && (addr == 12'h004) && wdata[n];
        nrun = m_run[n];
        nsp  = m_sp[n];
        if (st) begin nrun = 1; nsp = 0; end
        else if (ep[n] != 0 && m_sp[n] != 0) begin nrun = 0; nsp = 0; end
        else if (we && addr == 12'h008 && wdata[n] && m_run[n] != 0) nsp = 1;
        npre = st ? 0 : (tk[n] != 0) ? 0 : (m_pre[n] + 1) % 1024;
        ncnt = st ? 0 : (m_run[n] != 0 && tk[n] != 0) ? ((ep[n] != 0) ? 0 : m_cnt[n] + 1) : m_cnt[n];
        m_duty[n] = nd; m_prd[n] = np; m_run[n] = nrun; m_sp[n] = nsp;
        m_pre[n] = npre; m_cnt[n] = ncnt;
      end
    end
  end

  task automatic chk(string what, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    logic [3:0] ep_pin, ep_run;
    if (armed && !done) begin
      for (int n = 0; n < 4; n++) begin
        ep_pin[n] = m_pin[n][0];
        ep_run[n] = m_run[n][0];
      end
      chk("pwm_o", {28'b0, pwm}, {28'b0, ep_pin});
      chk("run_o", {28'b0, run}, {28'b0, ep_run});
      chk("rdata_o", rdata, m_rd);
    end
  end

  task automatic finish_up();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      n_bad++;
      $display("FAIL %s watchdog actual=%0d expected<150000", tag, cyc);
      finish_up();
    end
  end

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk); addr = a; wdata = d; we = 1'b1;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a);
    @(negedge clk); addr = a; re = 1'b1;
    @(negedge clk); re = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    // R1: reset state
    tag = "R1";
    idle(3);
    rst = 1'b0;
    rd(12'h00C); rd(12'h01C); rd(12'h200); rd(12'h20C); rd(12'h270);
    idle(3);
    // R9: map, 16-bit fields, unmapped reads
    tag = "R9";
    wr(12'h204, 32'hABC1_2345); rd(12'h204);
    wr(12'h230, 32'hFFFF_0011); rd(12'h230);
    rd(12'h100); rd(12'h214); rd(12'h280); rd(12'h27C); rd(12'h004); rd(12'h008);
    // R5: waveform, duty >= period, period zero
    tag = "R5";
    wr(12'h20C, 10); wr(12'h204, 3);
    wr(12'h22C, 5);  wr(12'h224, 7);
    wr(12'h244, 0);
    wr(12'h004, 32'h7);
    idle(60);
    // R4: prescaler, including clamp of exponent 15
    tag = "R4";
    wr(12'h220, 2);
    wr(12'h26C, 2); wr(12'h264, 1); wr(12'h260, 15);
    wr(12'h004, 32'h8);
    idle(4200);
    // R6: polarity
    tag = "R6";
    wr(12'h200, 32'h200); idle(30);
    wr(12'h240, 32'h200); idle(20);
    // R7: shadowed updates, active writes ignored while running
    tag = "R7";
    wr(12'h208, 6); wr(12'h210, 8);
    rd(12'h204); rd(12'h208); rd(12'h210);
    wr(12'h204, 1); rd(12'h204);
    idle(40);
    rd(12'h204); rd(12'h20C);
    // R8: event register clear on read
    tag = "R8";
    repeat (6) begin rd(12'h01C); idle(3); end
    // R2: zero bits ignored, restart of a running channel
    tag = "R2";
    wr(12'h004, 0); idle(10);
    wr(12'h004, 32'h1); idle(12);
    rd(12'h00C);
    // R3: deferred stop, ignored stop, direct write after stop
    tag = "R3";
    idle(3);
    wr(12'h008, 32'h1);
    repeat (12) rd(12'h00C);
    wr(12'h008, 32'h1);
    wr(12'h008, 32'h2);
    idle(20);
    wr(12'h204, 2); rd(12'h204);
    rd(12'h01C); idle(5);
    finish_up();
  end
endmodule